// File: doc/BRIEF.md
# Per-Core Interrupt Status and Mailbox Register Block

This block is the register file one processor core uses to receive doorbell interrupts and short messages. It holds a pending-status word, an enable word and eight message words. Software reaches them through a 32-bit register port. Two write-only strobes change the status word: one sets bits and one clears them. A single level interrupt output tells the core that enabled work is pending.

The interrupt line is not recomputed from status and enable on every cycle. Instead, only writes to the set and clear strobes move it, as the requirements below describe. Every access is accepted in the cycle it is presented, so the port has no back-pressure and needs no ready signal. Read data and the error flag are registered and appear one cycle after the access. Only the low eight address bits take part in decode. Offsets are status 0x00, enable 0x04, set strobe 0x08, clear strobe 0x0C, and message words 0x20 + 4*i. Data is 32-bit little-endian.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset, status, enable, all message words, the interrupt output, the read data and the error flag are all zero.
- R2: Address bits above bit 7 are ignored, so an offset decodes the same whatever the upper bits hold.
- R3: A write to offset 0x08 ORs the write data into status. If the new status ANDed with enable is nonzero, the interrupt output is high from the next cycle. Otherwise the output keeps its level.
- R4: A write to offset 0x0C clears in status every bit that is 1 in the write data. The interrupt output goes low only if the new status is zero and enable is nonzero. Otherwise it keeps its level.
- R5: A write to offset 0x04 stores enable and leaves the interrupt output unchanged.
- R6: Reads of offsets 0x08 and 0x0C return zero.
- R7: Eight message words at offsets 0x20, 0x24, through 0x3C (word i at 0x20 + 4*i) each store a written value and read it back.
- R8: A write to status at offset 0x00 does not change status and raises the error flag. A read of 0x00 returns status, and a read of 0x04 returns enable.
- R9: A read of any other offset, including one that is not word aligned, returns zero and raises the error flag. A write to such an offset changes no register and also raises the flag.
- R10: Read data appears on the cycle after a read access and holds until the next read. The error flag is a one-cycle pulse in that same cycle and is low when no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte address; low 8 bits decoded |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse for an invalid access |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The bench builds the block with its defaults: a 12-bit address and eight message words. This lets random upper address bits test that they are ignored, and lets the whole 256-byte decode window be swept, including unaligned offsets and the first word past the last message word. The write data is drawn from sparse single-bit and full masks, and enable is sometimes zeroed. This brings in the cases where a clear empties status while enable is zero, so the interrupt line must stay high.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 8'h04;
  localparam logic [OFS_W-1:0] OFS_SET    = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_MBOX   = 8'h20;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_STATUS, TGT_ENABLE, TGT_SET, TGT_CLEAR, TGT_MBOX
  } tgt_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regs_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [OFS_W-1:0] ofs,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] mbox_idx
);
  localparam logic [OFS_W-1:0] MB_SPAN = OFS_W'(MBOX_WORDS * 4);

  logic [OFS_W-1:0] rel;
  assign rel = ofs - OFS_MBOX;
  assign mbox_idx = rel[IDX_W+1:2];

  always_comb begin
    tgt = TGT_NONE;
    if (ofs == OFS_STATUS) tgt = TGT_STATUS;
    else if (ofs == OFS_ENABLE) tgt = TGT_ENABLE;
    else if (ofs == OFS_SET) tgt = TGT_SET;
    else if (ofs == OFS_CLEAR) tgt = TGT_CLEAR;
    else if (ofs >= OFS_MBOX && rel < MB_SPAN && rel[1:0] == 2'b00) tgt = TGT_MBOX;
  end
endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_enable,
  input  logic              we_set,
  input  logic              we_clear,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  logic [DATA_W-1:0] st_or, st_andn;
  assign st_or   = status | wdata;
  assign st_andn = status & ~wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (we_enable) enable <= wdata;
      if (we_set) begin
        status <= st_or;
        if (st_or != '0 && (st_or & enable) != '0) irq <= 1'b1;
      end
      if (we_clear) begin
        status <= st_andn;
        if (st_andn == '0 && enable != '0) irq <= 1'b0;
      end
    end
  end

  // R3: set write with enabled pending bits raises the line
  a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    we_set && ((status | wdata) & enable) != '0 |=> irq);
  // R4: clear leaving enabled-empty condition unmet keeps the line
  a_r4_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    we_clear && !((status & ~wdata) == '0 && enable != '0) |=> $stable(irq));
  // R4: clear emptying status with enable nonzero lowers the line
  a_r4_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    we_clear && (status & ~wdata) == '0 && enable != '0 |=> !irq);
  // R5: enable write alone leaves the line
  a_r5_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    we_enable && !we_set && !we_clear |=> $stable(irq));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[g] <= '0;
      else if (we && idx == IDX_W'(g)) word_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (idx == IDX_W'(i)) rdata = word_q[i];
  end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_err,
  output logic              irq_o
);
  tgt_e              tgt;
  logic [IDX_W-1:0]  mbox_idx;
  logic [DATA_W-1:0] status, enable, mbox_rdata;
  logic              wr, rd, bad;

  assign wr = acc_en && acc_wr;
  assign rd = acc_en && !acc_wr;

  ipi_addr_decode #(.MBOX_WORDS(MBOX_WORDS)) u_dec (
    .ofs(acc_addr[OFS_W-1:0]), .tgt(tgt), .mbox_idx(mbox_idx)
  );

  ipi_status_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .we_enable(wr && tgt == TGT_ENABLE),
    .we_set(wr && tgt == TGT_SET),
    .we_clear(wr && tgt == TGT_CLEAR),
    .wdata(acc_wdata), .status(status), .enable(enable), .irq(irq_o)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .WORDS(MBOX_WORDS)) u_mbox (
    .clk(clk), .rst_n(rst_n), .we(wr && tgt == TGT_MBOX),
    .idx(mbox_idx), .wdata(acc_wdata), .rdata(mbox_rdata)
  );

  assign bad = acc_en && (tgt == TGT_NONE || (acc_wr && tgt == TGT_STATUS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      acc_err <= bad;
      if (rd) begin
        unique case (tgt)
          TGT_STATUS: acc_rdata <= status;
          TGT_ENABLE: acc_rdata <= enable;
          TGT_MBOX:   acc_rdata <= mbox_rdata;
          default:    acc_rdata <= '0;
        endcase
      end
    end
  end

  // R8: status write discarded and flagged
  a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    wr && tgt == TGT_STATUS |=> $stable(status) && acc_err);
  // R9: undecoded access flags
  a_r9_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && tgt == TGT_NONE |=> acc_err);
  // R6: strobe offsets read zero
  a_r6_strobe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (tgt == TGT_SET || tgt == TGT_CLEAR) |=> acc_rdata == '0);
  // R10: no access, no flag, read data held
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !acc_err && $stable(acc_rdata));
endmodule

// File: tb/ipi_core_regs_test.sv
`timescale 1ns/1ps
module ipi_core_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err, irq_o;

  int tests = 0, fails = 0;
  logic [31:0] m_st = 0, m_en = 0, m_rd = 0;
  logic [31:0] m_mb [8];
  logic        m_irq = 0;

  always #2.5 clk = ~clk;

  ipi_core_regs uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none,1 status,2 enable,3 set,4 clear,5 mbox
  function automatic int classify(logic [7:0] o);
    if (o == 8'h00) return 1;
    if (o == 8'h04) return 2;
    if (o == 8'h08) return 3;
    if (o == 8'h0C) return 4;
    if (o >= 8'h20 && o <= 8'h3C && o[1:0] == 2'b00) return 5;
    return 0;
  endfunction

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d, string tag);
    int  c = classify(a[7:0]);
    bit  e;
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0;
    e = (c == 0) || (wr && c == 1);
    if (wr) begin
      case (c)
        2: m_en = d;
        3: begin m_st |= d; if (m_st != 0 && (m_st & m_en) != 0) m_irq = 1; end
        4: begin m_st &= ~d; if (m_st == 0 && m_en != 0) m_irq = 0; end
        5: m_mb[(a[7:0] - 8'h20) >> 2] = d;
        default: ;
      endcase
    end else begin
      case (c)
        1: m_rd = m_st;
        2: m_rd = m_en;
        5: m_rd = m_mb[(a[7:0] - 8'h20) >> 2];
        default: m_rd = 0;
      endcase
      chk({tag, " R10 rdata"}, acc_rdata, m_rd);
    end
    chk({tag, " R9 err"}, {31'b0, acc_err}, {31'b0, e});
    chk({tag, " R3/R4 irq"}, {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  function automatic logic [31:0] pick_data();
    case ($urandom % 4)
      0: return 32'h1 << ($urandom % 32);
      1: return 32'hFFFF_FFFF;
      2: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_mb[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 err", {31'b0, acc_err}, 0);
    chk("R1 rdata", acc_rdata, 0);
    access(0, 12'h000, 0, "R1 status");
    access(0, 12'h004, 0, "R1 enable");
    for (int i = 0; i < 8; i++) access(0, 12'h020 + 12'(4*i), 0, "R1 mbox");

    // R7 mailbox fill and read back, R2 upper bits varied
    for (int i = 0; i < 8; i++) access(1, 12'h020 + 12'(4*i), 32'hA500_0000 + 32'(i), "R7 wr");
    for (int i = 0; i < 8; i++) access(0, 12'hF20 + 12'(4*i), 0, "R7 R2 rd");

    // R5 enable write with pending status leaves irq low
    access(1, 12'h008, 32'h0000_0010, "R3 set no-en");
    access(1, 12'h004, 32'h0000_0010, "R5 en");
    chk("R5 irq stays low", {31'b0, irq_o}, 0);
    access(1, 12'h008, 32'h0000_0001, "R3 set raise");
    chk("R3 raised", {31'b0, irq_o}, 1);
    // R4 clear to zero with enable zero keeps irq high
    access(1, 12'h004, 32'h0, "R5 en zero");
    access(1, 12'h00C, 32'hFFFF_FFFF, "R4 clear en0");
    chk("R4 held high", {31'b0, irq_o}, 1);
    access(1, 12'h004, 32'h1, "R5 en");
    access(1, 12'h008, 32'h2, "R3 set masked");
    access(1, 12'h00C, 32'h2, "R4 clear lowers");
    chk("R4 lowered", {31'b0, irq_o}, 0);
    // R8 status write, R6 strobes, R9 unaligned / past end
    access(1, 12'h000, 32'hFFFF_FFFF, "R8 st wr");
    access(0, 12'h000, 0, "R8 st rd");
    access(0, 12'h008, 0, "R6 set rd");
    access(0, 12'h00C, 0, "R6 clr rd");
    access(1, 12'h022, 32'h1234, "R9 unaligned wr");
    access(1, 12'h040, 32'h1234, "R9 past end wr");
    access(0, 12'h040, 0, "R9 past end rd");
    access(0, 12'h020, 0, "R9 mbox intact");
    @(negedge clk);
    chk("R10 idle err", {31'b0, acc_err}, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      case ($urandom % 8)
        0: a = 12'h000; 1: a = 12'h004; 2, 3: a = 12'h008; 4: a = 12'h00C;
        5: a = 12'h020 + 12'(4 * ($urandom % 8));
        default: a = 12'($urandom);
      endcase
      a[11:8] = 4'($urandom);
      access($urandom % 2, a, pick_data(), "R2 rand");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule